// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Word Receiver

This block takes one control word from a three-wire serial link made of a data line, a serial clock and a frame enable. It places the word into output registers that steer a frequency synthesizer. The frame enable marks a transfer window. While the window is open, each falling serial clock edge moves one data bit into a shift register, and a counter records how many bits arrived. When the window closes, the word is committed only if it has exactly the expected length. Any frame that is too short or too long is thrown away.

The committed word has two parts: a group of port switch bits and a divider ratio. A ratio of zero is a request to turn the synthesizer off, so the block raises a PLL-off flag whenever the committed ratio is zero. The charge-pump current select is held at its high setting at all times.

The three link inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are then detected in the system clock domain. The system clock must therefore run several times faster than the serial clock.

Top module: `tw_word_rx`

## Requirements
- R1: On each falling edge of the serial clock inside an enable-high window, the data bit is shifted in. The bits arrive in this order: the 4 port bits with the top port bit first, then the 15-bit ratio MSB first and LSB last. The committed port bits are word[18:15] and the ratio is word[14:0].
- R2: Serial clock edges that occur while enable is low have no effect on the shift register or on the bit count.
- R3: Each rising edge of enable clears the bit count and the shift register, so earlier bursts do not affect the next frame.
- R4: On a falling edge of enable with exactly 19 counted bits, the shifted word is copied to the port and ratio outputs.
- R5: On a falling edge of enable with any count other than 19 (for example 18 or 20), the outputs keep their previous values.
- R6: The bit count saturates at 20, so a burst of 51 pulses does not wrap around and commit.
- R7: The PLL-off output is 1 exactly when the committed ratio is zero.
- R8: The charge-pump select output is constantly 1, which selects high current.
- R9: After reset, the ports and the ratio are zero and PLL-off is 1.
- R10: The outputs change on the third system clock rising edge after the enable input falls (two synchronizer flops, then the commit register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_en | input | 1 | Frame enable; a high level opens the window, and the falling edge commits |
| port_bits | output | PORT_W (4) | Committed port switch bits |
| div_ratio | output | RATIO_W (15) | Committed divider ratio |
| pll_off | output | 1 | High when the committed ratio is zero |
| cp_high | output | 1 | Charge-pump current select, held high |

## Verification
The bench builds the block with its default values: 4 port bits, a 15-bit ratio, a 19-bit word and a 5-bit saturating count. With these values, short and long frames of 18, 20 and 51 pulses can be sent in a few hundred cycles. The 51-pulse frame matters because it would land back on 19 if a 5-bit counter were allowed to wrap. The bench also holds each serial level for four system clocks, which makes the three-cycle commit latency visible. The bench compares the block against a behavioural model on every clock.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;
   // width needed to count up to one past the word length
   function automatic int cnt_width(input int word_w);
      return $clog2(word_w + 2);
   endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync_edge: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         last <= '0;
      end else begin
         chain[0] <= async_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         last <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~last;
   assign fall = ~lvl & last;
endmodule

// File: rtl/tw_shift_count.sv
module tw_shift_count #(
   parameter int WORD_W = 19,
   parameter int CNT_W  = tw_rx_pkg::cnt_width(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lvl,
   input  logic              en_rise,
   input  logic              sclk_fall,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

   if ((1 << CNT_W) <= WORD_W + 1) begin : g_bad_cnt
      $error("tw_shift_count: CNT_W too narrow for saturation value");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         cnt  <= '0;
      end else if (en_rise) begin
         word <= '0;
         cnt  <= '0;
      end else if (en_lvl && sclk_fall) begin
         word <= {word[WORD_W-2:0], din};
         if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tw_word_latch.sv
module tw_word_latch #(
   parameter int PORT_W  = 4,
   parameter int RATIO_W = 15,
   parameter int WORD_W  = PORT_W + RATIO_W,
   parameter int CNT_W   = tw_rx_pkg::cnt_width(WORD_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_fall,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [WORD_W-1:0]  word,
   output logic [PORT_W-1:0]  port_bits,
   output logic [RATIO_W-1:0] div_ratio,
   output logic               pll_off,
   output logic               cp_high
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W != PORT_W + RATIO_W) begin : g_bad_split
      $error("tw_word_latch: WORD_W must equal PORT_W + RATIO_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_bits <= '0;
         div_ratio <= '0;
      end else if (en_fall && (cnt == CNT_FULL)) begin
         port_bits <= word[WORD_W-1 -: PORT_W];
         div_ratio <= word[RATIO_W-1:0];
      end
   end

   assign pll_off = (div_ratio == '0);
   assign cp_high = 1'b1;
endmodule

// File: rtl/tw_word_rx.sv
module tw_word_rx #(
   parameter int PORT_W      = 4,
   parameter int RATIO_W     = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_data,
   input  logic               ser_clk,
   input  logic               ser_en,
   output logic [PORT_W-1:0]  port_bits,
   output logic [RATIO_W-1:0] div_ratio,
   output logic               pll_off,
   output logic               cp_high
);
   localparam int WORD_W = PORT_W + RATIO_W;
   localparam int CNT_W  = tw_rx_pkg::cnt_width(WORD_W);

   if (PORT_W < 1 || RATIO_W < 1) begin : g_bad_width
      $error("tw_word_rx: field widths must be positive");
   end

   // bit 2 = enable, bit 1 = serial clock, bit 0 = data
   logic [2:0] s_lvl, s_rise, s_fall;
   logic              en_lvl, en_rise, en_fall, sclk_fall, din;
   logic [WORD_W-1:0] word;
   logic [CNT_W-1:0]  cnt;

   tw_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ser_en, ser_clk, ser_data}),
      .lvl      (s_lvl),
      .rise     (s_rise),
      .fall     (s_fall)
   );

   assign en_lvl    = s_lvl[2];
   assign en_rise   = s_rise[2];
   assign en_fall   = s_fall[2];
   assign sclk_fall = s_fall[1];
   assign din       = s_lvl[0];

   tw_shift_count #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_lvl    (en_lvl),
      .en_rise   (en_rise),
      .sclk_fall (sclk_fall),
      .din       (din),
      .word      (word),
      .cnt       (cnt)
   );

   tw_word_latch #(.PORT_W(PORT_W), .RATIO_W(RATIO_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_fall   (en_fall),
      .cnt       (cnt),
      .word      (word),
      .port_bits (port_bits),
      .div_ratio (div_ratio),
      .pll_off   (pll_off),
      .cp_high   (cp_high)
   );
endmodule

// File: rtl/tw_word_rx_chk.sv
module tw_word_rx_chk #(
   parameter int PORT_W  = 4,
   parameter int RATIO_W = 15,
   parameter int WORD_W  = 19,
   parameter int CNT_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_lvl,
   input logic               en_rise,
   input logic               en_fall,
   input logic [CNT_W-1:0]   cnt,
   input logic [WORD_W-1:0]  word,
   input logic [PORT_W-1:0]  port_bits,
   input logic [RATIO_W-1:0] div_ratio
);
   AST_NO_SHIFT_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |=> ($stable(cnt) && $stable(word))); // R2

   AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> (cnt == '0 && word == '0)); // R3

   AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fall && cnt == CNT_W'(WORD_W)) |=>
         (div_ratio == $past(word[RATIO_W-1:0]) && port_bits == $past(word[WORD_W-1 -: PORT_W]))); // R4

   AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_fall && cnt == CNT_W'(WORD_W)) |=> ($stable(div_ratio) && $stable(port_bits))); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WORD_W + 1)); // R6
endmodule

bind tw_word_rx tw_word_rx_chk #(
   .PORT_W(PORT_W), .RATIO_W(RATIO_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_lvl    (en_lvl),
   .en_rise   (en_rise),
   .en_fall   (en_fall),
   .cnt       (cnt),
   .word      (word),
   .port_bits (port_bits),
   .div_ratio (div_ratio)
);

// File: tb/tb_tw_word_rx.sv
module tb_tw_word_rx;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
   logic [3:0]  port_bits;
   logic [14:0] div_ratio;
   logic        pll_off, cp_high;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tw_word_rx dut (
      .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en(ser_en),
      .port_bits(port_bits), .div_ratio(div_ratio), .pll_off(pll_off), .cp_high(cp_high)
   );

   // behavioural reference model
   logic [2:0]  pipe[$];
   logic [2:0]  m_prev;
   int          m_cnt;
   logic [18:0] m_sr;
   logic [3:0]  m_port;
   logic [14:0] m_ratio;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe = {3'b000, 3'b000};
         m_prev = 3'b000; m_cnt = 0; m_sr = '0; m_port = '0; m_ratio = '0;
      end else begin
         logic [2:0] cur;
         cur = pipe[0];
         if (!cur[2] && m_prev[2]) begin
            if (m_cnt == 19) begin
               m_port  = m_sr[18:15];
               m_ratio = m_sr[14:0];
            end
         end else if (cur[2] && !m_prev[2]) begin
            m_cnt = 0; m_sr = '0;
         end else if (cur[2] && !cur[1] && m_prev[1]) begin
            m_sr = {m_sr[17:0], cur[0]};
            if (m_cnt < 20) m_cnt++;
         end
         m_prev = cur;
         void'(pipe.pop_front());
         pipe.push_back({ser_en, ser_clk, ser_data});
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R10 model ratio", div_ratio, m_ratio);
         check("R1 model ports", port_bits, m_port);
         check("R7 model pll_off", pll_off, (m_ratio == 0));
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // open window, send npulse bits (word bits first, zeros after), optionally close
   task automatic burst(input int npulse, input logic [18:0] w, input bit close);
      ser_en = 1'b1; wait_clk(HOLD);
      for (int i = 0; i < npulse; i++) begin
         ser_data = (i < 19) ? w[18-i] : 1'b0;
         ser_clk = 1'b1; wait_clk(HOLD);
         ser_clk = 1'b0; wait_clk(HOLD);
      end
      if (close) begin
         ser_en = 1'b0; wait_clk(2 * HOLD);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      check("R9 reset ratio", div_ratio, 0);
      check("R9 reset ports", port_bits, 0);
      check("R9 reset pll_off", pll_off, 1);
      check("R8 cp_high", cp_high, 1);

      burst(19, {4'hA, 15'h1234}, 1);
      check("R4 commit ratio", div_ratio, 15'h1234);
      check("R1 commit ports", port_bits, 4'hA);
      check("R7 pll_off low", pll_off, 0);

      burst(18, {4'h3, 15'h0555}, 1);
      check("R5 short frame ratio", div_ratio, 15'h1234);
      burst(20, {4'h3, 15'h0555}, 1);
      check("R5 long frame ratio", div_ratio, 15'h1234);
      check("R5 long frame ports", port_bits, 4'hA);

      burst(51, {4'h6, 15'h7001}, 1);
      check("R6 saturation ratio", div_ratio, 15'h1234);

      // pulses with enable low
      for (int i = 0; i < 19; i++) begin
         ser_data = 1'b1;
         ser_clk = 1'b1; wait_clk(HOLD);
         ser_clk = 1'b0; wait_clk(HOLD);
      end
      check("R2 low pulses ratio", div_ratio, 15'h1234);
      check("R2 low pulses ports", port_bits, 4'hA);

      // aborted partial then full frame: clear at rise
      burst(10, 19'h7FFFF, 1);
      burst(19, {4'h5, 15'h0001}, 1);
      check("R3 after partial ratio", div_ratio, 15'h0001);
      check("R3 after partial ports", port_bits, 4'h5);

      // latency: close manually
      burst(19, {4'hC, 15'h4321}, 0);
      ser_en = 1'b0;
      wait_clk(2);
      check("R10 not yet", div_ratio, 15'h0001);
      wait_clk(1);
      check("R10 committed", div_ratio, 15'h4321);
      check("R1 ports C", port_bits, 4'hC);
      wait_clk(HOLD);

      burst(19, {4'h9, 15'h0000}, 1);
      check("R7 zero ratio pll_off", pll_off, 1);
      check("R7 zero ratio ports", port_bits, 4'h9);
      burst(19, {4'h0, 15'h4000}, 1);
      check("R7 msb ratio pll_off", pll_off, 0);
      check("R1 msb ratio", div_ratio, 15'h4000);
      check("R8 cp_high end", cp_high, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule